// File: doc/BRIEF.md
# Branch Resolution Unit

This unit settles control flow for a 32-bit core that has one branch delay slot. On each strobe it takes the address of a branch or jump, the instruction word and the two source register values. It decides whether the transfer is taken and computes where fetch continues after the delay slot. It also reports whether the delay slot must be discarded and whether the link register (register 31) receives a return address. An undefined sub-code in the single-register test group raises a trap flag and has no other effect.

All results appear one clock after the strobe. The unit does not fetch instructions, own the register file or vector exceptions. The pipeline uses `redir_pc` together with the flags to steer fetch and to squash the delay-slot instruction.

Top module: `branch_resolve`

## Requirements
- R1: `res_valid` rises exactly one cycle after a cycle with `in_valid` high, and is low in the cycle after a cycle with `in_valid` low. The other result outputs change only on strobed cycles.
- R2: Opcode 2 (jump) and opcode 3 (jump-and-link) are always taken. Their target is bits 31:28 of `pc`+4 followed by `instr[25:0]` and then two zero bits.
- R3: A conditional branch that is taken redirects to `pc` + 4 + (sign-extended `instr[15:0]` shifted left by 2). A branch that is not taken continues at `pc` + 8.
- R4: Opcodes 4 and 20 are taken when `op_a` equals `op_b`. Opcodes 5 and 21 are taken when they differ.
- R5: Opcodes 6 and 22 are taken when `op_a` has its sign bit set or is zero. Opcodes 7 and 23 are taken when its sign bit is clear and it is nonzero.
- R6: Opcode 1 decodes a sub-code from `instr[20:16]`. Bit 0 of the sub-code selects "sign clear" (1) or "sign set" (0) of `op_a` as the take condition.
- R7: Jump-and-link and sub-codes 0x10 to 0x13 assert `link_we` with `link_data` = `pc` + 8, whether or not the branch is taken.
- R8: Opcodes 20 to 23 and sub-codes whose bit 1 is set are likely forms. When such a branch is not taken, `annul` is high. `annul` is never high for a taken branch or for a non-likely one.
- R9: Under opcode 1, a sub-code outside {0,1,2,3,0x10,0x11,0x12,0x13} sets `trap` and clears `taken`, `annul` and `link_we`.
- R10: Any other opcode gives `is_cf`=0, `taken`=0, `annul`=0, `link_we`=0, and `redir_pc` = `pc`+4.
- R11: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: inputs hold an instruction to resolve |
| pc | input | 32 | Address of the instruction |
| instr | input | 32 | Instruction word |
| op_a | input | 32 | First source register value |
| op_b | input | 32 | Second source register value |
| res_valid | output | 1 | Results below belong to the previous strobe |
| is_cf | output | 1 | Instruction was a control-flow instruction |
| taken | output | 1 | Transfer is taken |
| annul | output | 1 | Discard the delay-slot instruction |
| redir_pc | output | 32 | Fetch address following the delay slot |
| link_we | output | 1 | Write `link_data` into register 31 |
| link_data | output | 32 | Return address |
| trap | output | 1 | Undefined single-register test sub-code |

## Verification
Every result, including the link write and the trap, is due in the single cycle after the strobe. The bench drives a strobe on a falling edge and samples on the following falling edge, so exactly one rising edge lies between stimulus and check. In the next idle cycle it confirms that `res_valid` has dropped while the other outputs keep their values. Expected addresses and flags come from a reference function written from the requirements. The taken decision is also checked against a hand-written column of the vector table.

// File: rtl/branch_resolve.sv
module branch_resolve #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] instr,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         res_valid,
  output logic         is_cf,
  output logic         taken,
  output logic         annul,
  output logic [W-1:0] redir_pc,
  output logic         link_we,
  output logic [W-1:0] link_data,
  output logic         trap
);
  localparam int IDX = 26;
  localparam int IMM = 16;
  localparam int SEXT = W - IMM - 2;

  logic [5:0]   opc;
  logic [4:0]   sub;
  logic [W-1:0] seq_pc, fall_pc, br_tgt, j_tgt;
  logic         eq, neg, zero;

  assign opc     = instr[31:26];
  assign sub     = instr[20:16];
  assign seq_pc  = pc + W'(4);
  assign fall_pc = pc + W'(8);
  assign br_tgt  = seq_pc + {{SEXT{instr[IMM-1]}}, instr[IMM-1:0], 2'b00};
  assign j_tgt   = {seq_pc[W-1:W-4], instr[IDX-1:0], 2'b00};
  assign eq      = (op_a == op_b);
  assign neg     = op_a[W-1];
  assign zero    = (op_a == '0);

  logic         cf, cond, likely, lnk, bad;
  logic [W-1:0] tgt;

  always_comb begin
    cf = 1'b1; cond = 1'b0; likely = 1'b0; lnk = 1'b0; bad = 1'b0; tgt = br_tgt;
    unique case (opc)
      6'd2: begin cond = 1'b1; tgt = j_tgt; end
      6'd3: begin cond = 1'b1; tgt = j_tgt; lnk = 1'b1; end
      6'd4, 6'd20: begin cond = eq;            likely = opc[4]; end
      6'd5, 6'd21: begin cond = !eq;           likely = opc[4]; end
      6'd6, 6'd22: begin cond = neg || zero;   likely = opc[4]; end
      6'd7, 6'd23: begin cond = !neg && !zero; likely = opc[4]; end
      6'd1: begin
        if (sub[3:2] == 2'b00) begin
          cond   = sub[0] ? !neg : neg;
          likely = sub[1];
          lnk    = sub[4];
        end else begin
          bad = 1'b1;
        end
      end
      default: cf = 1'b0;
    endcase
  end

  logic         tk_n, an_n;
  logic [W-1:0] nxt_n;

  assign tk_n  = cf && cond && !bad;
  assign an_n  = cf && likely && !cond && !bad;
  assign nxt_n = tk_n ? tgt : (cf ? fall_pc : seq_pc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      is_cf     <= 1'b0;
      taken     <= 1'b0;
      annul     <= 1'b0;
      redir_pc  <= '0;
      link_we   <= 1'b0;
      link_data <= '0;
      trap      <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        is_cf     <= cf;
        taken     <= tk_n;
        annul     <= an_n;
        redir_pc  <= nxt_n;
        link_we   <= lnk && !bad;
        link_data <= (lnk && !bad) ? fall_pc : '0;
        trap      <= bad;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);
  // R8
  annul_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    annul |-> !taken && is_cf);
  // R9
  trap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !taken && !annul && !link_we);
  // R7
  link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!link_we || link_data == $past(pc) + W'(8)));
  // R2
  jump_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (instr[31:27] == 5'b00001) |=> taken);
endmodule

// File: tb/sim_branch_resolve.sv
module sim_branch_resolve;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] pc = '0, instr = '0, op_a = '0, op_b = '0;
  logic        res_valid, is_cf, taken, annul, link_we, trap;
  logic [31:0] redir_pc, link_data;

  always #4 clk = ~clk;

  branch_resolve u0 (.clk, .rst_n, .in_valid, .pc, .instr, .op_a, .op_b,
    .res_valid, .is_cf, .taken, .annul, .redir_pc, .link_we, .link_data, .trap);

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  localparam int NV = 26;
  // {pc, instr, a, b, expected taken}
  localparam logic [128:0] VEC [NV] = '{
    {32'h0040_0000, 32'h0800_0100, 32'd0, 32'd0, 1'b1},
    {32'hEFFF_FFFC, 32'h0C00_0040, 32'd0, 32'd0, 1'b1},
    {32'h0000_1000, 32'h1000_0004, 32'd5, 32'd5, 1'b1},
    {32'h0000_1000, 32'h1000_0004, 32'd5, 32'd6, 1'b0},
    {32'h0000_2000, 32'h1400_FFFE, 32'd1, 32'd2, 1'b1},
    {32'h0000_2000, 32'h1400_FFFE, 32'd7, 32'd7, 1'b0},
    {32'h0000_3000, 32'h1800_0010, 32'd0, 32'd0, 1'b1},
    {32'h0000_3000, 32'h1800_0010, 32'h8000_0000, 32'd0, 1'b1},
    {32'h0000_3000, 32'h1800_0010, 32'd1, 32'd0, 1'b0},
    {32'h0000_3000, 32'h1C00_0010, 32'd1, 32'd0, 1'b1},
    {32'h0000_3000, 32'h1C00_0010, 32'd0, 32'd0, 1'b0},
    {32'h0000_3000, 32'h1C00_0010, 32'hFFFF_FFFF, 32'd0, 1'b0},
    {32'h0000_4000, 32'h5000_0008, 32'd1, 32'd2, 1'b0},
    {32'h0000_4000, 32'h5400_0008, 32'd1, 32'd2, 1'b1},
    {32'h0000_4000, 32'h5800_0008, 32'd5, 32'd0, 1'b0},
    {32'h0000_4000, 32'h5C00_0008, 32'd0, 32'd0, 1'b0},
    {32'h0000_5000, 32'h0400_0020, 32'h8000_0000, 32'd0, 1'b1},
    {32'h0000_5000, 32'h0401_0020, 32'h8000_0000, 32'd0, 1'b0},
    {32'h0000_5000, 32'h0402_0020, 32'd1, 32'd0, 1'b0},
    {32'h0000_5000, 32'h0403_0020, 32'd0, 32'd0, 1'b1},
    {32'h0000_5000, 32'h0410_0020, 32'd1, 32'd0, 1'b0},
    {32'h0000_5000, 32'h0411_0020, 32'd1, 32'd0, 1'b1},
    {32'h0000_5000, 32'h0412_0020, 32'hFFFF_FFF0, 32'd0, 1'b1},
    {32'h0000_5000, 32'h0413_0020, 32'hFFFF_FFF0, 32'd0, 1'b0},
    {32'h0000_5000, 32'h0405_0020, 32'd1, 32'd0, 1'b0},
    {32'h0000_6000, 32'h2400_0001, 32'd1, 32'd0, 1'b0}
  };
  localparam string TAG [NV] = '{"R2","R2","R4","R4","R4","R4","R5","R5","R5",
    "R5","R5","R5","R8","R8","R8","R8","R6","R6","R8","R6","R7","R7","R7",
    "R7","R9","R10"};

  // {is_cf, taken, annul, link_we, trap, redir_pc, link_data}
  function automatic logic [68:0] ref_model(input logic [31:0] p, i, a, b);
    logic c = 1'b1, t = 1'b0, lk = 1'b0, li = 1'b0, tr = 1'b0;
    logic [31:0] dst;
    int o = int'(i[31:26]);
    int s = int'(i[20:16]);
    dst = p + 32'd4 + (32'(signed'(i[15:0])) <<< 2);
    if (o == 2 || o == 3) begin
      t = 1'b1; lk = (o == 3);
      dst = {p[31:28] + ((p[27:0] >= 28'hFFFFFFC) ? 4'd1 : 4'd0), i[25:0], 2'b00};
    end else if (o == 4 || o == 20) begin t = (a == b); li = (o == 20); end
    else if (o == 5 || o == 21) begin t = (a != b); li = (o == 21); end
    else if (o == 6 || o == 22) begin t = ($signed(a) <= 0); li = (o == 22); end
    else if (o == 7 || o == 23) begin t = ($signed(a) > 0); li = (o == 23); end
    else if (o == 1) begin
      if (s == 0 || s == 2 || s == 16 || s == 18) t = ($signed(a) < 0);
      else if (s == 1 || s == 3 || s == 17 || s == 19) t = ($signed(a) >= 0);
      else tr = 1'b1;
      li = (s == 2 || s == 3 || s == 18 || s == 19);
      lk = (s >= 16 && s <= 19);
    end else c = 1'b0;
    if (!c) return {5'b00000, p + 32'd4, 32'd0};
    return {1'b1, t, li && !t, lk, tr, t ? dst : p + 32'd8, lk ? p + 32'd8 : 32'd0};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  logic [68:0] e;
  logic [31:0] held;

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(res_valid == 0 && taken == 0 && annul == 0 && link_we == 0 && trap == 0,
        "R11", "flags", {27'd0, res_valid, taken, annul, link_we, trap}, 32'd0);
    chk(redir_pc == 0 && link_data == 0, "R11", "addr", redir_pc | link_data, 32'd0);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      {pc, instr, op_a, op_b} = VEC[k][128:1];
      in_valid = 1'b1;
      e = ref_model(pc, instr, op_a, op_b);
      @(negedge clk);
      in_valid = 1'b0;
      chk(res_valid, "R1", "valid", {31'd0, res_valid}, 32'd1);
      chk(taken == VEC[k][0], TAG[k], "taken", {31'd0, taken}, {31'd0, VEC[k][0]});
      chk(taken == e[67], TAG[k], "taken ref", {31'd0, taken}, {31'd0, e[67]});
      chk(redir_pc == e[63:32], (e[68] ? (instr[31:27] == 5'b00001 ? "R2" : "R3") : "R10"),
          "redir", redir_pc, e[63:32]);
      chk(annul == e[66], "R8", "annul", {31'd0, annul}, {31'd0, e[66]});
      chk(link_we == e[65] && link_data == e[31:0], "R7", "link", link_data, e[31:0]);
      chk(trap == e[64], "R9", "trap", {31'd0, trap}, {31'd0, e[64]});
      chk(is_cf == e[68], "R10", "is_cf", {31'd0, is_cf}, {31'd0, e[68]});
      held = redir_pc;
      instr = 32'h0800_0000;
      @(negedge clk);
      // R1 no strobe: valid drops, results hold
      chk(!res_valid, "R1", "valid drop", {31'd0, res_valid}, 32'd0);
      chk(redir_pc == held, "R1", "hold", redir_pc, held);
    end
    // R11 reset in mid-run clears results
    @(negedge clk);
    pc = 32'h100; instr = 32'h0C00_0001; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk(!res_valid && !taken && !link_we && redir_pc == 0, "R11", "mid reset",
        redir_pc, 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion"); end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule